// File: doc/BRIEF.md
# Frame Quality CRC Encoder and Checker

This block protects a fixed-size serial information frame with a 12-bit frame-quality code. On the transmit side it accepts 172 information bits, one per valid strobe, with the first bit marked by a start-of-frame strobe. It passes each bit through one cycle later. It then emits, without further input, the 12 check bits and 8 zero tail bits. The result is a 192-bit coded frame with its own valid and start-of-frame outputs. The check value is the remainder of the data under the generator x^12 + x^11 + x^10 + x^9 + x^8 + x^4 + x + 1, with the register preset to all ones.

On the receive side a separate path takes a 192-bit coded frame. It runs bits 0 through 183 (data plus check bits) through an identical register and inspects bits 184 through 191. One cycle after the last bit it pulses a completion strobe. It also updates a good-frame flag, which is set only when the remainder is zero and every tail bit is zero, and which holds its value until the next frame completes. A start-of-frame strobe in the middle of a frame, on either path, drops the partial frame and begins a new one.

Top module: `fq_crc_codec`

## Requirements
- R1: After reset, tx_out_valid, tx_out_sof, rx_frame_done and rx_frame_ok are all 0.
- R2: A transmit bit accepted with tx_in_valid appears on tx_out_bit one cycle later, with tx_out_valid high. tx_out_sof is high only for frame position 0, and positions 0..171 carry the information bits in arrival order.
- R3: Output positions 172..183 carry the 12-bit remainder, most significant bit first. The remainder comes from a left-shifting register preset to all ones when the start-of-frame bit is taken. For each information bit, the register shifts left with feedback = (bit 11 XOR input bit), and the shifted value is XORed with 0xF13 when the feedback is 1.
- R4: Output positions 184..191 are 0. The 20 trailer positions follow the last information bit on consecutive cycles, so a frame is exactly 192 output bits.
- R5: Transmit input with tx_in_valid high and tx_in_sof low is ignored when no frame is open or while the trailer is being emitted. Receive input with rx_in_valid high and rx_in_sof low is ignored when no frame is open.
- R6: A start-of-frame strobe in the middle of a frame, on either path, abandons the partial frame without emitting a trailer or a completion. The strobed bit becomes position 0 of a new frame.
- R7: The receive path pulses rx_frame_done one cycle after accepting position 191. At that pulse, rx_frame_ok is 1 when the register (same preset and update as R3, applied to positions 0..183) is zero and positions 184..191 are all 0.
- R8: rx_frame_ok is 0 after a frame whose data or check bits give a nonzero remainder, or whose tail holds any 1.
- R9: rx_frame_done is a single-cycle pulse, and rx_frame_ok keeps its value between completions, including across partial and abandoned frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_in_valid | input | 1 | Transmit information bit present |
| tx_in_sof | input | 1 | Marks the first information bit of a frame |
| tx_in_bit | input | 1 | Transmit information bit |
| tx_out_valid | output | 1 | Coded output bit present |
| tx_out_sof | output | 1 | Marks position 0 of the coded frame |
| tx_out_bit | output | 1 | Coded frame bit |
| rx_in_valid | input | 1 | Received coded bit present |
| rx_in_sof | input | 1 | Marks position 0 of a received frame |
| rx_in_bit | input | 1 | Received coded bit |
| rx_frame_done | output | 1 | One-cycle pulse after a full received frame |
| rx_frame_ok | output | 1 | Good-frame verdict of the last completed frame |

## Verification
The encoder is driven with an all-zero frame, an all-one frame, an alternating frame and a pseudo-random frame. The all-zero case isolates the all-ones preset from the data. All-ones and alternating expose a wrong tap or a wrong shift direction, and the random frame catches an off-by-one in the data count. A run with idle gaps between input bits shows that the count follows the valid strobe and not the clock. Bench-encoded frames go to the checker unchanged, and again with a single flipped data bit, a flipped check bit or a set tail bit. These separate the remainder test from the tail test. Aborted and partial frames on both paths show that a frame restarts on a new strobe and that the verdict is held.

// File: rtl/fq_crc_pkg.sv
// Shared constants and state types for the frame-quality CRC codec.
// Assumes a single clock domain and bit-serial operation.
package fq_crc_pkg;

    localparam int FQ_DATA_BITS = 172;
    localparam int FQ_CRC_W     = 12;
    localparam int FQ_TAIL_BITS = 8;
    localparam logic [FQ_CRC_W-1:0] FQ_POLY = 12'hF13;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_DATA  = 2'd1,
        TX_TRAIL = 2'd2
    } tx_phase_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_phase_e;

endpackage

// File: rtl/fq_crc_reg.sv
// Bit-serial CRC remainder register, MSB-first, Galois form.
// load presets the register to all ones before the step in the same cycle.
// step folds din into the remainder; shift moves the remainder out MSB-first.
// step has priority over shift. Assumes callers never need both at once.
module fq_crc_reg #(
    parameter int               W    = 12,
    parameter logic [W-1:0]     POLY = 12'hF13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] crc
);

    logic [W-1:0] crc_q;
    logic [W-1:0] base;
    logic [W-1:0] stepped;
    logic         fb;

    // Next remainder when one data bit is folded in.
    always_comb begin
        base    = load ? {W{1'b1}} : crc_q;
        fb      = base[W-1] ^ din;
        stepped = {base[W-2:0], 1'b0} ^ (fb ? POLY : {W{1'b0}});
    end

    // Remainder storage: fold a bit, or shift out toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= {W{1'b1}};
        end else if (step) begin
            crc_q <= stepped;
        end else if (shift) begin
            crc_q <= {crc_q[W-2:0], 1'b0};
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/fq_crc_tx.sv
// Transmit side: passes information bits through with one cycle of latency.
// After the last one it emits the check bits MSB-first and then zero tail
// bits, on consecutive cycles. A start strobe always opens a new frame.
// Assumes DATA_BITS >= 2 and TAIL_BITS >= 1.
module fq_crc_tx
    import fq_crc_pkg::*;
#(
    parameter int                  DATA_BITS = FQ_DATA_BITS,
    parameter int                  CRC_W     = FQ_CRC_W,
    parameter int                  TAIL_BITS = FQ_TAIL_BITS,
    parameter logic [CRC_W-1:0]    POLY      = FQ_POLY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_bit,
    output logic out_valid,
    output logic out_sof,
    output logic out_bit
);

    localparam int FRAME_BITS = DATA_BITS + CRC_W + TAIL_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS - 1);
    localparam logic [CNT_W-1:0] CHK_END   = CNT_W'(DATA_BITS + CRC_W);
    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_BITS - 1);

    tx_phase_e         phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CRC_W-1:0]  crc;
    logic              take_sof;
    logic              take_data;
    logic              emit_chk;

    // Classify this cycle: new frame, data bit, or check-bit emission.
    always_comb begin
        take_sof  = in_valid && in_sof;
        take_data = in_valid && !in_sof && (phase_q == TX_DATA);
        emit_chk  = (phase_q == TX_TRAIL) && (cnt_q < CHK_END) && !take_sof;
    end

    fq_crc_reg #(
        .W    (CRC_W),
        .POLY (POLY)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take_sof),
        .step  (take_sof || take_data),
        .shift (emit_chk),
        .din   (in_bit),
        .crc   (crc)
    );

    // Frame sequencing and the registered serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= TX_IDLE;
            cnt_q     <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_bit   <= 1'b0;
        end else if (take_sof) begin
            phase_q   <= TX_DATA;
            cnt_q     <= CNT_W'(1);
            out_valid <= 1'b1;
            out_sof   <= 1'b1;
            out_bit   <= in_bit;
        end else if (take_data) begin
            phase_q   <= (cnt_q == LAST_DATA) ? TX_TRAIL : TX_DATA;
            cnt_q     <= cnt_q + 1'b1;
            out_valid <= 1'b1;
            out_sof   <= 1'b0;
            out_bit   <= in_bit;
        end else if (phase_q == TX_TRAIL) begin
            out_valid <= 1'b1;
            out_sof   <= 1'b0;
            out_bit   <= emit_chk ? crc[CRC_W-1] : 1'b0;
            if (cnt_q == LAST_POS) begin
                phase_q <= TX_IDLE;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_bit   <= 1'b0;
        end
    end

endmodule

// File: rtl/fq_crc_rx.sv
// Receive side: folds positions 0..CRC end into a remainder register and
// watches the tail positions for ones. One cycle after the last position
// it pulses done and updates the held good-frame verdict.
// A start strobe always opens a new frame. Assumes TAIL_BITS >= 1.
module fq_crc_rx
    import fq_crc_pkg::*;
#(
    parameter int                  DATA_BITS = FQ_DATA_BITS,
    parameter int                  CRC_W     = FQ_CRC_W,
    parameter int                  TAIL_BITS = FQ_TAIL_BITS,
    parameter logic [CRC_W-1:0]    POLY      = FQ_POLY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_bit,
    output logic frame_done,
    output logic frame_ok
);

    localparam int FRAME_BITS = DATA_BITS + CRC_W + TAIL_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] CHK_END  = CNT_W'(DATA_BITS + CRC_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    rx_phase_e         phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CRC_W-1:0]  crc;
    logic              tail_bad_q;
    logic              take_sof;
    logic              take_more;
    logic              in_tail;

    // Classify this cycle and whether the accepted bit is a tail bit.
    always_comb begin
        take_sof  = in_valid && in_sof;
        take_more = in_valid && !in_sof && (phase_q == RX_BUSY);
        in_tail   = cnt_q >= CHK_END;
    end

    fq_crc_reg #(
        .W    (CRC_W),
        .POLY (POLY)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take_sof),
        .step  (take_sof || (take_more && !in_tail)),
        .shift (1'b0),
        .din   (in_bit),
        .crc   (crc)
    );

    // Position count, tail watch, completion pulse and held verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= RX_IDLE;
            cnt_q      <= '0;
            tail_bad_q <= 1'b0;
            frame_done <= 1'b0;
            frame_ok   <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (take_sof) begin
                phase_q    <= RX_BUSY;
                cnt_q      <= CNT_W'(1);
                tail_bad_q <= 1'b0;
            end else if (take_more) begin
                if (cnt_q == LAST_POS) begin
                    phase_q    <= RX_IDLE;
                    cnt_q      <= '0;
                    frame_done <= 1'b1;
                    frame_ok   <= (crc == '0) && !tail_bad_q && !in_bit;
                end else begin
                    cnt_q      <= cnt_q + 1'b1;
                    tail_bad_q <= tail_bad_q || (in_tail && in_bit);
                end
            end
        end
    end

endmodule

// File: rtl/fq_crc_codec.sv
// Top of the frame-quality codec: an independent encoder and checker
// sharing only clock, reset and parameters.
module fq_crc_codec
    import fq_crc_pkg::*;
#(
    parameter int                  DATA_BITS = FQ_DATA_BITS,
    parameter int                  CRC_W     = FQ_CRC_W,
    parameter int                  TAIL_BITS = FQ_TAIL_BITS,
    parameter logic [CRC_W-1:0]    POLY      = FQ_POLY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_in_valid,
    input  logic tx_in_sof,
    input  logic tx_in_bit,
    output logic tx_out_valid,
    output logic tx_out_sof,
    output logic tx_out_bit,
    input  logic rx_in_valid,
    input  logic rx_in_sof,
    input  logic rx_in_bit,
    output logic rx_frame_done,
    output logic rx_frame_ok
);

    fq_crc_tx #(
        .DATA_BITS (DATA_BITS),
        .CRC_W     (CRC_W),
        .TAIL_BITS (TAIL_BITS),
        .POLY      (POLY)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_in_valid),
        .in_sof    (tx_in_sof),
        .in_bit    (tx_in_bit),
        .out_valid (tx_out_valid),
        .out_sof   (tx_out_sof),
        .out_bit   (tx_out_bit)
    );

    fq_crc_rx #(
        .DATA_BITS (DATA_BITS),
        .CRC_W     (CRC_W),
        .TAIL_BITS (TAIL_BITS),
        .POLY      (POLY)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rx_in_valid),
        .in_sof     (rx_in_sof),
        .in_bit     (rx_in_bit),
        .frame_done (rx_frame_done),
        .frame_ok   (rx_frame_ok)
    );

endmodule

// File: rtl/fq_crc_codec_chk.sv
// Property checker for fq_crc_codec, attached by bind. It keeps its own
// count of emitted output positions to judge frame layout on the ports.
module fq_crc_codec_chk #(
    parameter int DATA_BITS = 172,
    parameter int CRC_W     = 12,
    parameter int TAIL_BITS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic tx_in_valid,
    input logic tx_in_sof,
    input logic tx_out_valid,
    input logic tx_out_sof,
    input logic tx_out_bit,
    input logic rx_frame_done,
    input logic rx_frame_ok
);

    localparam int FRAME_BITS = DATA_BITS + CRC_W + TAIL_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS + 2);
    localparam logic [POS_W-1:0] P_LAST_DATA = POS_W'(DATA_BITS - 1);
    localparam logic [POS_W-1:0] P_TAIL      = POS_W'(DATA_BITS + CRC_W);
    localparam logic [POS_W-1:0] P_LAST      = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] P_FRAME     = POS_W'(FRAME_BITS);

    logic [POS_W-1:0] pos_q;

    // Number of coded bits emitted since the last output start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (tx_out_valid) begin
            pos_q <= tx_out_sof ? POS_W'(1) : ((pos_q < P_FRAME) ? pos_q + 1'b1 : pos_q);
        end
    end

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_sof) |=> (tx_out_valid && tx_out_sof)); // R2

    AST_SOF_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_sof |-> tx_out_valid); // R2

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_out_sof) |-> ((pos_q != '0) && (pos_q < P_FRAME))); // R4

    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_out_sof && (pos_q >= P_TAIL)) |-> !tx_out_bit); // R4

    AST_TRAILER_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_out_sof && (pos_q >= P_LAST_DATA) && (pos_q < P_LAST))
        |=> tx_out_valid); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_done |=> !rx_frame_done); // R9

    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_frame_done |-> $stable(rx_frame_ok)); // R9

endmodule

bind fq_crc_codec fq_crc_codec_chk #(
    .DATA_BITS (DATA_BITS),
    .CRC_W     (CRC_W),
    .TAIL_BITS (TAIL_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_in_valid   (tx_in_valid),
    .tx_in_sof     (tx_in_sof),
    .tx_out_valid  (tx_out_valid),
    .tx_out_sof    (tx_out_sof),
    .tx_out_bit    (tx_out_bit),
    .rx_frame_done (rx_frame_done),
    .rx_frame_ok   (rx_frame_ok)
);

// File: tb/fq_crc_codec_tb_top.sv
`timescale 1ns/1ps
// Directed bench for fq_crc_codec: one task per scenario, each self-checking.
module fq_crc_codec_tb_top;

    localparam int DATA_BITS = 172;
    localparam int FRAME     = 192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_in_valid = 1'b0, tx_in_sof = 1'b0, tx_in_bit = 1'b0;
    logic rx_in_valid = 1'b0, rx_in_sof = 1'b0, rx_in_bit = 1'b0;
    logic tx_out_valid, tx_out_sof, tx_out_bit;
    logic rx_frame_done, rx_frame_ok;

    always #2 clk = ~clk;

    fq_crc_codec dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_in_valid   (tx_in_valid),
        .tx_in_sof     (tx_in_sof),
        .tx_in_bit     (tx_in_bit),
        .tx_out_valid  (tx_out_valid),
        .tx_out_sof    (tx_out_sof),
        .tx_out_bit    (tx_out_bit),
        .rx_in_valid   (rx_in_valid),
        .rx_in_sof     (rx_in_sof),
        .rx_in_bit     (rx_in_bit),
        .rx_frame_done (rx_frame_done),
        .rx_frame_ok   (rx_frame_ok)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Count a check and report a mismatch.
    task automatic chk(input logic ok, input string req,
                       input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output capture of the coded stream and completion pulses.
    logic [191:0] cap = '0;
    int cap_n = 0;
    int tx_valid_cnt = 0;
    int tx_sof_cnt = 0;
    int done_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_out_valid) begin
                tx_valid_cnt++;
                if (tx_out_sof) begin
                    cap_n = 0;
                    tx_sof_cnt++;
                end
                if (cap_n < FRAME) cap[cap_n] = tx_out_bit;
                cap_n++;
            end
            if (rx_frame_done) done_cnt++;
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Reference encoding from R3/R4: preset ones, MSB-first, 0xF13 feedback.
    function automatic logic [191:0] ref_encode(input logic [171:0] d);
        logic [11:0]  c = 12'hFFF;
        logic [191:0] e = '0;
        logic         fb;
        for (int i = 0; i < DATA_BITS; i++) begin
            e[i] = d[i];
            fb   = c[11] ^ d[i];
            c    = {c[10:0], 1'b0};
            if (fb) c = c ^ 12'hF13;
        end
        for (int k = 0; k < 12; k++) e[DATA_BITS + k] = c[11 - k];
        return e;
    endfunction

    // Test patterns: 0 zeros, 1 ones, 2 alternating, 3 pseudo-random.
    function automatic logic [171:0] gen_data(input int kind);
        logic [171:0] d = '0;
        logic [15:0]  s = 16'hACE1;
        for (int i = 0; i < DATA_BITS; i++) begin
            case (kind)
                0: d[i] = 1'b0;
                1: d[i] = 1'b1;
                2: d[i] = i[0];
                default: begin
                    s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
                    d[i] = s[0];
                end
            endcase
        end
        return d;
    endfunction

    // Drive nbits transmit bits; optional gaps and busy input during trailer.
    task automatic tx_drive(input logic [171:0] d, input int nbits,
                            input bit gaps, input bit busy_trail);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            tx_in_valid = 1'b1;
            tx_in_sof   = (i == 0);
            tx_in_bit   = d[i];
            if (gaps && (i % 3 == 1) && (i < nbits - 1)) begin
                @(negedge clk);
                tx_in_valid = 1'b0;
                tx_in_sof   = 1'b0;
            end
        end
        if (busy_trail) begin
            for (int j = 0; j < 20; j++) begin
                @(negedge clk);
                tx_in_valid = 1'b1;
                tx_in_sof   = 1'b0;
                tx_in_bit   = 1'b1;
            end
        end
        @(negedge clk);
        tx_in_valid = 1'b0;
        tx_in_sof   = 1'b0;
        tx_in_bit   = 1'b0;
        repeat (26) @(negedge clk);
    endtask

    // Compare a captured coded frame with the reference encoding.
    task automatic tx_check_frame(input logic [171:0] d, input string tag);
        logic [191:0] e = ref_encode(d);
        chk(cap_n == FRAME, {"R4 frame length ", tag}, 192'(cap_n), 192'(FRAME));
        chk(cap[171:0] == d, {"R2 data bits ", tag}, 192'(cap[171:0]), 192'(d));
        chk(cap[183:172] == e[183:172], {"R3 check bits ", tag},
            192'(cap[183:172]), 192'(e[183:172]));
        chk(cap[191:184] == 8'h00, {"R4 tail bits ", tag}, 192'(cap[191:184]), 192'(0));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!tx_out_valid && !tx_out_sof, "R1 tx idle", 192'({tx_out_valid, tx_out_sof}), 192'(0));
        chk(!rx_frame_done, "R1 done low", 192'(rx_frame_done), 192'(0));
        chk(!rx_frame_ok, "R1 ok low", 192'(rx_frame_ok), 192'(0));
    endtask

    task automatic t_tx_pattern(input int kind, input bit gaps, input string tag);
        logic [171:0] d = gen_data(kind);
        cap_n = 0;
        tx_sof_cnt = 0;
        tx_drive(d, DATA_BITS, gaps, 1'b0);
        tx_check_frame(d, tag);
        chk(tx_sof_cnt == 1, {"R2 one start ", tag}, 192'(tx_sof_cnt), 192'(1));
    endtask

    task automatic t_tx_ignore();
        tx_valid_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            tx_in_valid = 1'b1;
            tx_in_sof   = 1'b0;
            tx_in_bit   = 1'b1;
        end
        @(negedge clk);
        tx_in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_valid_cnt == 0, "R5 idle input ignored", 192'(tx_valid_cnt), 192'(0));
        cap_n = 0;
        tx_drive(gen_data(3), DATA_BITS, 1'b0, 1'b1);
        tx_check_frame(gen_data(3), "R5 busy trailer");
    endtask

    task automatic t_tx_abort();
        tx_valid_cnt = 0;
        tx_drive(gen_data(3), 50, 1'b0, 1'b0);
        chk(tx_valid_cnt == 50, "R6 no trailer after partial", 192'(tx_valid_cnt), 192'(50));
        cap_n = 0;
        tx_valid_cnt = 0;
        tx_drive(gen_data(2), DATA_BITS, 1'b0, 1'b0);
        tx_check_frame(gen_data(2), "R6 restart");
        chk(tx_valid_cnt == FRAME, "R6 restart count", 192'(tx_valid_cnt), 192'(FRAME));
    endtask

    // Drive nbits receive bits; report done/ok right after and done one later.
    task automatic rx_drive(input logic [191:0] f, input int nbits, input bit gaps,
                            input bit use_sof, output logic dn, output logic ok,
                            output logic dn2);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            rx_in_valid = 1'b1;
            rx_in_sof   = use_sof && (i == 0);
            rx_in_bit   = f[i];
            if (gaps && (i % 5 == 2) && (i < nbits - 1)) begin
                @(negedge clk);
                rx_in_valid = 1'b0;
                rx_in_sof   = 1'b0;
            end
        end
        @(negedge clk);
        dn = rx_frame_done;
        ok = rx_frame_ok;
        rx_in_valid = 1'b0;
        rx_in_sof   = 1'b0;
        rx_in_bit   = 1'b0;
        @(negedge clk);
        dn2 = rx_frame_done;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_rx_frame(input logic [191:0] f, input bit gaps,
                              input logic exp_ok, input string req);
        logic dn, ok, dn2;
        rx_drive(f, FRAME, gaps, 1'b1, dn, ok, dn2);
        chk(dn == 1'b1, {"R7 done after last bit ", req}, 192'(dn), 192'(1));
        chk(ok == exp_ok, req, 192'(ok), 192'(exp_ok));
        chk(dn2 == 1'b0, {"R9 single pulse ", req}, 192'(dn2), 192'(0));
    endtask

    task automatic t_rx_hold_abort();
        logic dn, ok, dn2;
        logic [191:0] good = ref_encode(gen_data(1));
        logic [191:0] bad  = good;
        int d0;
        bad[100] = ~bad[100];
        t_rx_frame(bad, 1'b0, 1'b0, "R8 flipped data");
        d0 = done_cnt;
        rx_drive(good, 100, 1'b0, 1'b1, dn, ok, dn2);
        chk(ok == 1'b0 && done_cnt == d0, "R9 verdict held over partial",
            192'({done_cnt - d0, ok}), 192'(0));
        rx_drive(good, 30, 1'b0, 1'b0, dn, ok, dn2);
        t_rx_frame(good, 1'b0, 1'b1, "R6 restart after partial");
        chk(done_cnt == d0 + 1, "R6 one completion", 192'(done_cnt - d0), 192'(1));
        rx_drive(bad, 60, 1'b0, 1'b1, dn, ok, dn2);
        chk(ok == 1'b1, "R9 good verdict held", 192'(ok), 192'(1));
    endtask

    task automatic t_rx_ignore();
        logic dn, ok, dn2;
        logic [191:0] good = ref_encode(gen_data(2));
        logic [191:0] bad  = good;
        int d0;
        bad[180] = ~bad[180];
        t_rx_frame(bad, 1'b0, 1'b0, "R8 flipped check bit");
        d0 = done_cnt;
        rx_drive(good, FRAME, 1'b0, 1'b0, dn, ok, dn2);
        chk(done_cnt == d0 && ok == 1'b0, "R5 rx input without start ignored",
            192'({done_cnt - d0, ok}), 192'(0));
    endtask

    initial begin
        logic [191:0] f;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();

        t_tx_pattern(0, 1'b0, "zeros");
        t_tx_pattern(1, 1'b0, "ones");
        t_tx_pattern(2, 1'b0, "alternating");
        t_tx_pattern(3, 1'b0, "random");
        t_tx_pattern(3, 1'b1, "random gaps");
        t_tx_ignore();
        t_tx_abort();

        t_rx_frame(ref_encode(gen_data(3)), 1'b0, 1'b1, "R7 good random");
        t_rx_frame(ref_encode(gen_data(0)), 1'b1, 1'b1, "R7 good zeros gaps");
        f = ref_encode(gen_data(3));
        f[40] = ~f[40];
        t_rx_frame(f, 1'b0, 1'b0, "R8 flipped data bit");
        f = ref_encode(gen_data(3));
        f[190] = 1'b1;
        t_rx_frame(f, 1'b0, 1'b0, "R8 tail bit set");
        f = ref_encode(gen_data(3));
        f[191] = 1'b1;
        t_rx_frame(f, 1'b0, 1'b0, "R8 last tail bit set");
        t_rx_hold_abort();
        t_rx_ignore();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule